// File: doc/BRIEF.md
# Parallel Instruction Boundary Marker

This block finds instruction boundaries in an instruction stream in which every instruction is either 4 or 8 bytes long. Each cycle it accepts one 16-byte aligned fetch block and cuts it into four 4-byte lanes. For each lane it reports one of three results: the lane starts an instruction, the lane is the second half of an 8-byte instruction, or the lane holds an illegal encoding. It also reports whether each starting instruction is 8 bytes long.

The length and legality of an instruction depend only on its first 12 bits. These are the opcode byte and the high nibble of the second byte. A programmable table of 4096 two-bit entries maps those 12 bits to a result. Because the table answers without looking further into the instruction, all four lanes look up their table entries at the same time. A short chain then passes a "spill" signal from each lane to the lane on its right, so a lane knows when an 8-byte instruction from the left covers it.

An 8-byte instruction that starts in the last lane spills into the first lane of the next block. The block keeps this in a one-bit carry. A redirect or flush input clears the carry. The results are registered and appear one cycle after the block is accepted.

Top module: `insn_boundary_marker`

## Requirements
- R1: Lane i covers bytes 4i to 4i+3 of `fetch_data`, with byte 0 in bits [7:0]. The 12-bit table index of a lane is {first byte, high nibble of the second byte}, which is {word[7:0], word[15:12]} of the lane's 32-bit word.
- R2: A table entry is written on a clock edge while `tbl_wr_en` is 1, with `tbl_wr_data` bit 1 = legal and bit 0 = 8 bytes long. `fetch_ready` is 0 in any cycle in which `tbl_wr_en` is 1.
- R3: A lane to the right of a lane that starts a legal 8-byte instruction is a continuation. For that lane, `mark_start`, `mark_long` and `mark_illegal` are all 0.
- R4: A lane that is not a continuation has `mark_start` = 1. It has `mark_illegal` = 1 if its entry is not legal, and it then counts as 4 bytes long (`mark_long` = 0). Otherwise `mark_long` is equal to the entry's long bit.
- R5: With ADDR32 = 1, a lane whose 4-bit mode nibble (word[15:12]) ends in binary 11 is illegal, whatever its table entry says.
- R6: A legal 8-byte instruction that starts in the last lane makes lane 0 of the next accepted block a continuation.
- R7: A `redirect` pulse clears the spill carry. A block accepted in the same cycle as `redirect` is decoded with no incoming spill.
- R8: `mark_valid` is 1 in the cycle after a fetch block is accepted (`fetch_valid` and `fetch_ready` both 1), and 0 otherwise.
- R9: Every marked block has at least two lanes with `mark_start` = 1.
- R10: After reset, `mark_valid` is 0 and the spill carry is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect | input | 1 | Flush: clears the spill carry |
| fetch_valid | input | 1 | A fetch block is present |
| fetch_ready | output | 1 | The block can accept a fetch block |
| fetch_data | input | 128 | Fetch block, byte 0 in the low bits |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 12 | Table entry index |
| tbl_wr_data | input | 2 | {legal, long} |
| mark_valid | output | 1 | The marks below are valid |
| mark_start | output | 4 | Lane starts an instruction |
| mark_long | output | 4 | The instruction starting in the lane is 8 bytes |
| mark_illegal | output | 4 | Lane starts an illegal encoding |

## Verification
The bench builds the block with its default parameters: four lanes and ADDR32 = 1. This means the mode-nibble rule is active, so random words hit the forced-illegal case about one time in four. The bench loads the full 4096-entry table. It then checks the marks against a reference that walks the byte stream one instruction at a time. Random words make spills cross block boundaries often.

The bench also runs directed cases:
- redirects during a spill
- resets during a spill
- a table rewrite
- gaps between fetch blocks

// File: rtl/ibm_pkg.sv
package ibm_pkg;
  localparam int OPC_BITS  = 8;
  localparam int SUB_BITS  = 4;
  localparam int PFX_BITS  = OPC_BITS + SUB_BITS;
  localparam int WORD_BITS = 32;

  typedef struct packed {
    logic legal;
    logic is_long;
  } tbl_ent_t;

  typedef struct packed {
    logic start;
    logic is_long;
    logic illegal;
  } lane_mark_t;

  function automatic logic [PFX_BITS-1:0] lane_index(input logic [WORD_BITS-1:0] w);
    return {w[OPC_BITS-1:0], w[2*OPC_BITS-1 -: SUB_BITS]};
  endfunction
endpackage

// File: rtl/ibm_len_table.sv
module ibm_len_table
  import ibm_pkg::*;
#(
  parameter int RD_PORTS = 4,
  localparam int DEPTH = 1 << PFX_BITS
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [PFX_BITS-1:0]          wr_addr,
  input  tbl_ent_t                     wr_data,
  input  logic [RD_PORTS*PFX_BITS-1:0] rd_addr,
  output tbl_ent_t [RD_PORTS-1:0]      rd_data
);
  tbl_ent_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p*PFX_BITS +: PFX_BITS]];
  end
endmodule

// File: rtl/ibm_lane.sv
module ibm_lane
  import ibm_pkg::*;
#(
  parameter bit ADDR32 = 1'b1
) (
  input  logic [PFX_BITS-1:0] index,
  input  tbl_ent_t            ent,
  input  logic                spill_in,
  output lane_mark_t          mark,
  output logic                spill_out
);
  logic mode_bad;
  logic legal;

  always_comb begin
    mode_bad     = ADDR32 && (index[1:0] == 2'b11);
    legal        = ent.legal && !mode_bad;
    mark.start   = !spill_in;
    mark.illegal = !spill_in && !legal;
    mark.is_long = !spill_in && legal && ent.is_long;
    spill_out    = mark.is_long;
  end
endmodule

// File: rtl/insn_boundary_marker.sv
module insn_boundary_marker
  import ibm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter bit ADDR32 = 1'b1,
  localparam int DW    = LANES * WORD_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                redirect,
  input  logic                fetch_valid,
  output logic                fetch_ready,
  input  logic [DW-1:0]       fetch_data,
  input  logic                tbl_wr_en,
  input  logic [PFX_BITS-1:0] tbl_wr_addr,
  input  logic [1:0]          tbl_wr_data,
  output logic                mark_valid,
  output logic [LANES-1:0]    mark_start,
  output logic [LANES-1:0]    mark_long,
  output logic [LANES-1:0]    mark_illegal
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic                      accept;
  logic [LANES*PFX_BITS-1:0] idx_bus;
  tbl_ent_t [LANES-1:0]      ent_bus;
  lane_mark_t [LANES-1:0]    lane_mark;
  logic [LANES:0]            spill;
  logic                      carry_q, carry_d;
  logic                      vld_d;
  logic [LANES-1:0]          st_d, lg_d, il_d;

  assign fetch_ready = !tbl_wr_en;
  assign accept      = fetch_valid && fetch_ready;

  ibm_len_table #(.RD_PORTS(LANES)) u_tbl (
    .clk     (clk),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .rd_addr (idx_bus),
    .rd_data (ent_bus)
  );

  assign spill[0] = carry_q && !redirect;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign idx_bus[i*PFX_BITS +: PFX_BITS] = lane_index(fetch_data[i*WORD_BITS +: WORD_BITS]);
    ibm_lane #(.ADDR32(ADDR32)) u_lane (
      .index     (idx_bus[i*PFX_BITS +: PFX_BITS]),
      .ent       (ent_bus[i]),
      .spill_in  (spill[i]),
      .mark      (lane_mark[i]),
      .spill_out (spill[i+1])
    );
    assign st_d[i] = lane_mark[i].start;
    assign lg_d[i] = lane_mark[i].is_long;
    assign il_d[i] = lane_mark[i].illegal;
  end

  always_comb begin
    vld_d = accept;
    if (accept)        carry_d = spill[LANES];
    else if (redirect) carry_d = 1'b0;
    else               carry_d = carry_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      carry_q    <= 1'b0;
      mark_valid <= 1'b0;
    end else begin
      carry_q    <= carry_d;
      mark_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mark_start   <= '0;
      mark_long    <= '0;
      mark_illegal <= '0;
    end else if (accept) begin
      mark_start   <= st_d;
      mark_long    <= lg_d;
      mark_illegal <= il_d;
    end
  end
endmodule

// File: rtl/insn_boundary_marker_chk.sv
module insn_boundary_marker_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             redirect,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic             mark_valid,
  input logic [LANES-1:0] mark_start,
  input logic [LANES-1:0] mark_long,
  input logic [LANES-1:0] mark_illegal
);
  // R8
  valid_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> mark_valid);
  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_ready) |=> !mark_valid);
  // R9
  min_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |-> ($countones(mark_start) >= 2));
  // R3
  cont_after_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |-> ((mark_long[LANES-2:0] & mark_start[LANES-1:1]) == '0));
  // R4
  illegal_is_short_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |-> (((mark_illegal & ~mark_start) == '0) && ((mark_illegal & mark_long) == '0)));
  // R7
  redirect_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && fetch_valid && fetch_ready) |=> mark_start[0]);
  // R6
  carry_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_valid && mark_long[LANES-1] && !redirect && fetch_valid && fetch_ready) |=> !mark_start[0]);
endmodule

bind insn_boundary_marker insn_boundary_marker_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .redirect     (redirect),
  .fetch_valid  (fetch_valid),
  .fetch_ready  (fetch_ready),
  .mark_valid   (mark_valid),
  .mark_start   (mark_start),
  .mark_long    (mark_long),
  .mark_illegal (mark_illegal)
);

// File: tb/tb_insn_boundary_marker.sv
`timescale 1ns/1ps
module tb_insn_boundary_marker;
  localparam int LANES = 4;
  localparam int DW = LANES * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redirect = 1'b0;
  logic fetch_valid = 1'b0;
  logic fetch_ready;
  logic [DW-1:0] fetch_data = '0;
  logic tbl_wr_en = 1'b0;
  logic [11:0] tbl_wr_addr = '0;
  logic [1:0] tbl_wr_data = '0;
  logic mark_valid;
  logic [LANES-1:0] mark_start, mark_long, mark_illegal;

  always #2 clk = ~clk;

  insn_boundary_marker #(.LANES(LANES), .ADDR32(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .redirect(redirect),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .mark_valid(mark_valid), .mark_start(mark_start), .mark_long(mark_long),
    .mark_illegal(mark_illegal)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [1:0] btab [4096];
  bit ref_carry = 0;
  logic [3*LANES-1:0] expq [$];

  function automatic logic [1:0] entry_of(input int a);
    logic [11:0] x;
    x = a[11:0];
    return {(a % 5) != 0, x[3] ^ x[7] ^ x[10]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_entry(input int a, input logic [1:0] v);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = a[11:0]; tbl_wr_data = v;
    btab[a] = v;
  endtask

  // Reference walker: one lane at a time, carry held across blocks.
  function automatic logic [3*LANES-1:0] walk(input logic [DW-1:0] d, input bit fl);
    logic [LANES-1:0] s, l, il;
    bit cont;
    logic [31:0] w;
    logic [11:0] ix;
    bit legal;
    cont = fl ? 1'b0 : ref_carry;
    for (int i = 0; i < LANES; i++) begin
      w = d[i*32 +: 32];
      ix = {w[7:0], w[15:12]};
      if (cont) begin
        s[i] = 0; l[i] = 0; il[i] = 0; cont = 0;
      end else begin
        legal = btab[ix][1] && (ix[1:0] != 2'b11);
        s[i] = 1; il[i] = !legal; l[i] = legal && btab[ix][0];
        cont = l[i];
      end
    end
    ref_carry = cont;
    return {s, l, il};
  endfunction

  task automatic send(input logic [DW-1:0] d, input bit fl);
    @(negedge clk);
    tbl_wr_en = 1'b0;
    expq.push_back(walk(d, fl));
    fetch_valid = 1'b1; fetch_data = d; redirect = fl;
    @(negedge clk);
    fetch_valid = 1'b0; redirect = 1'b0;
  endtask

  task automatic send_burst(input logic [DW-1:0] d, input bit fl);
    expq.push_back(walk(d, fl));
    fetch_valid = 1'b1; fetch_data = d; redirect = fl;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mkword(input logic [11:0] ix);
    return {16'h0, ix[3:0], 4'h5, ix[11:4]};
  endfunction

  // Monitor: scoreboard
  always @(negedge clk) begin
    if (rst_n && mark_valid && !done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected mark_valid", 32'd1, 32'd0);
      end else begin
        logic [3*LANES-1:0] e;
        e = expq.pop_front();
        check({mark_start, mark_long, mark_illegal} == e,
              "R1/R3/R4/R5/R6/R7/R9 lane marks {start,long,illegal}",
              {20'h0, mark_start, mark_long, mark_illegal}, {20'h0, e});
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [11:0] lng, sht, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(mark_valid == 1'b0, "R10 mark_valid after reset", {31'h0, mark_valid}, 32'h0);

    for (int a = 0; a < 4096; a++) write_entry(a, entry_of(a));
    // R2: ready low while writing
    check(fetch_ready == 1'b0, "R2 fetch_ready during table write", {31'h0, fetch_ready}, 32'h0);
    @(negedge clk);
    tbl_wr_en = 1'b0;
    #0;
    check(fetch_ready == 1'b1, "R2 fetch_ready after table write", {31'h0, fetch_ready}, 32'h1);

    // pick a legal long, legal short and a forced-illegal index
    lng = 12'h000; sht = 12'h000; bad = 12'h003;
    for (int a = 4095; a >= 0; a--) begin
      logic [11:0] x;
      x = a[11:0];
      if (x[1:0] != 2'b11 && btab[a] == 2'b11) lng = x;
      if (x[1:0] != 2'b11 && btab[a] == 2'b10) sht = x;
      if (x[1:0] == 2'b11 && btab[a][1]) bad = x;
    end

    // directed: long in lane 3 spills into next block (R6)
    send({mkword(lng), mkword(sht), mkword(sht), mkword(sht)}, 1'b0);
    send({mkword(sht), mkword(sht), mkword(sht), mkword(sht)}, 1'b0);
    // R7: redirect with carry pending
    send({mkword(lng), mkword(sht), mkword(sht), mkword(sht)}, 1'b0);
    send({mkword(sht), mkword(sht), mkword(sht), mkword(lng)}, 1'b1);
    // R5: legal table entry with mode nibble ending 11
    send({mkword(sht), mkword(bad), mkword(sht), mkword(sht)}, 1'b0);
    // R3/R9: alternating long pattern
    send({mkword(sht), mkword(lng), mkword(sht), mkword(lng)}, 1'b0);
    // R8: gap cycle gives no mark_valid
    @(negedge clk);
    check(mark_valid == 1'b0, "R8 no mark_valid in idle cycle", {31'h0, mark_valid}, 32'h0);

    // R2: rewrite an entry to illegal and see it take effect
    write_entry(sht, 2'b00);
    send({mkword(sht), mkword(sht), mkword(sht), mkword(sht)}, 1'b0);
    write_entry(sht, 2'b10);
    @(negedge clk); tbl_wr_en = 1'b0;

    // R10: reset clears pending carry
    send({mkword(lng), mkword(sht), mkword(sht), mkword(sht)}, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    ref_carry = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mark_valid == 1'b0, "R10 mark_valid after mid-run reset", {31'h0, mark_valid}, 32'h0);
    send({mkword(sht), mkword(sht), mkword(sht), mkword(sht)}, 1'b0);

    // random streams, back-to-back with occasional gaps and redirects
    for (int b = 0; b < 400; b++) begin
      for (int i = 0; i < LANES; i++) d[i*32 +: 32] = $urandom;
      if (($urandom % 8) == 0) begin
        fetch_valid = 1'b0; redirect = ($urandom % 2) == 1;
        if (redirect) ref_carry = 0;
        @(negedge clk);
        redirect = 1'b0;
      end
      send_burst(d, ($urandom % 16) == 0);
    end
    fetch_valid = 1'b0; redirect = 1'b0;
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R8 all accepted blocks marked", expq.size(), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule